// File: doc/BRIEF.md
# DC Offset Removal Stage with Offset Hold

This stage sits behind a decimation filter in a stereo audio capture path. It tracks the slowly varying DC level of each channel's 24-bit two's-complement sample stream with a first-order integrator built from a shift, not a multiplier. On every accepted sample it subtracts the current estimate. The result is a high-pass response whose corner sits near 1 Hz at a 48 kHz rate with the default shift. The corner moves in proportion to the sample rate, because the integrator advances once per sample.

A single hold control stops both integrators from adapting. The offset they hold is still subtracted from every later sample. A system offset calibration therefore works in two steps: run with adaptation until the estimate has settled, then raise the hold. From then on the offset of the whole analog chain ahead of the converter is removed by a fixed amount.

Top module: `dc_trim_top`

## Requirements
- R1: While `rstN` is low, `outValid` is 0, both outputs are 0 and both integrators are cleared. The first sample accepted after reset therefore appears unchanged at the output.
- R2: `outValid` is high in exactly the clock cycle that follows a cycle with `inValid` high, and low in every other cycle.
- R3: For each accepted sample x, the output is x minus floor(acc / 2^GUARD), where acc is that channel's integrator value before this sample updates it.
- R4: When `freeze` is 0, each accepted sample updates its channel's integrator as acc <= acc + ((x * 2^GUARD - acc) >>> SHIFT), using an arithmetic shift. The defaults are SHIFT = 13 and GUARD = 13.
- R5: When `freeze` is 1 on an accepted sample, neither integrator changes, and the stored estimate is still subtracted from that sample.
- R6: A difference above 8388607 is output as 8388607 and a difference below -8388608 is output as -8388608. The output never wraps.
- R7: The left and right integrators are independent. A sample on one channel never changes the other channel's estimate.
- R8: Between accepted samples, both outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a cycle that carries one new sample pair |
| freeze | input | 1 | 1 holds both DC estimates; they are still subtracted |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| outValid | output | 1 | Marks the cycle that carries one filtered pair |
| leftOut | output | 24 | Filtered left sample, saturated |
| rightOut | output | 24 | Filtered right sample, saturated |

## Verification
A filtered pair is due exactly one rising edge after its input strobe. An integrator update made by that strobe shows up only in the output of the next accepted sample. The bench drives each sample on a falling edge and holds the strobe for one cycle. It reads `outValid` and both outputs on the next falling edge, after exactly one rising edge has passed. Its integer model advances the estimate only after it has computed the expected output, which keeps the one-sample lag of R3. Idle stretches are sampled on falling edges as well, to confirm the strobe stays low and the data stays still.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
  // Strobes that the control sends to each channel datapath
  typedef struct packed {
    logic capture;   // register a new filtered output
    logic adapt;     // advance the DC integrator
  } strobe_t;
endpackage

// File: rtl/dc_trim_ctrl.sv
module dc_trim_ctrl
  import dc_trim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    freeze,
  output strobe_t ctl,
  output logic    outValid
);
  always_comb begin
    ctl.capture = inValid;
    ctl.adapt   = inValid && !freeze;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/dc_trim_path.sv
module dc_trim_path
  import dc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 13,
  parameter int GUARD  = 13,
  localparam int ACC_W = DATA_W + GUARD
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  ctl,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic signed [ACC_W-1:0]  accState
);
  localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  accQ;
  logic signed [ACC_W-1:0]  estFull;
  logic signed [DATA_W-1:0] estWord;
  logic signed [DATA_W:0]   diffWide;
  logic signed [DATA_W-1:0] diffSat;
  logic signed [ACC_W:0]    target;
  logic signed [ACC_W:0]    delta;
  logic signed [ACC_W:0]    step;
  logic signed [ACC_W-1:0]  accNext;

  // Integer part of the estimate; always fits the sample width
  assign estFull = accQ >>> GUARD;
  assign estWord = estFull[DATA_W-1:0];

  // Output difference with one extra bit, then clamp
  assign diffWide = {sampleIn[DATA_W-1], sampleIn} - {estWord[DATA_W-1], estWord};
  always_comb begin
    if (diffWide[DATA_W] == diffWide[DATA_W-1]) diffSat = diffWide[DATA_W-1:0];
    else if (diffWide[DATA_W])                  diffSat = NEG_MIN;
    else                                        diffSat = POS_MAX;
  end

  // Shift-based leaky integrator: acc += (x - acc) >> SHIFT
  assign target  = {sampleIn[DATA_W-1], sampleIn, {GUARD{1'b0}}};
  assign delta   = target - {accQ[ACC_W-1], accQ};
  assign step    = delta >>> SHIFT;
  assign accNext = accQ + step[ACC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      sampleOut <= '0;
    end else begin
      if (ctl.adapt)   accQ      <= accNext;
      if (ctl.capture) sampleOut <= diffSat;
    end
  end

  assign accState = accQ;
endmodule

// File: rtl/dc_trim_top.sv
module dc_trim_top
  import dc_trim_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 13,
  parameter int GUARD  = 13,
  localparam int ACC_W = DATA_W + GUARD,
  localparam int NUM_CH = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              freeze,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic              outValid,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut
);
  strobe_t ctl;
  logic signed [DATA_W-1:0] chanIn  [NUM_CH];
  logic signed [DATA_W-1:0] chanOut [NUM_CH];
  logic signed [ACC_W-1:0]  accBus  [NUM_CH];

  assign chanIn[0] = leftIn;
  assign chanIn[1] = rightIn;
  assign leftOut   = chanOut[0];
  assign rightOut  = chanOut[1];

  dc_trim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .freeze(freeze),
    .ctl(ctl), .outValid(outValid)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dc_trim_path #(.DATA_W(DATA_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_path (
      .clk(clk), .rstN(rstN), .ctl(ctl),
      .sampleIn(chanIn[ch]), .sampleOut(chanOut[ch]), .accState(accBus[ch])
    );
  end
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 37
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              freeze,
  input logic              outValid,
  input logic [DATA_W-1:0] leftIn,
  input logic [DATA_W-1:0] rightIn,
  input logic [DATA_W-1:0] leftOut,
  input logic [DATA_W-1:0] rightOut,
  input logic [ACC_W-1:0]  accL,
  input logic [ACC_W-1:0]  accR
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && leftOut == '0 && rightOut == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(leftOut) && $stable(rightOut)));

  assert_frozen_estimate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && freeze) |=> ($stable(accL) && $stable(accR)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !leftIn[DATA_W-1] && accL[ACC_W-1]) |=> !leftOut[DATA_W-1]);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rightIn[DATA_W-1] && !accR[ACC_W-1]) |=> rightOut[DATA_W-1]);
endmodule

bind dc_trim_top dc_trim_chk #(.DATA_W(DATA_W), .ACC_W(DATA_W + GUARD)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .freeze(freeze),
  .outValid(outValid), .leftIn(leftIn), .rightIn(rightIn),
  .leftOut(leftOut), .rightOut(rightOut),
  .accL(accBus[0]), .accR(accBus[1])
);

// File: tb/dc_trim_top_tb.sv
`timescale 1ns/1ps
module dc_trim_top_tb;
  localparam int NV = 8;
  localparam int KSH = 13;
  localparam int PMAX = 8388607;
  localparam int NMIN = -8388608;
  // stimulus table: left, right, freeze; expected values come from the model
  localparam int  vecL [NV] = '{100000, -5000, 2000000, -7000000, 123, 8388607, -8388608, 42};
  localparam int  vecR [NV] = '{-300, 4000000, -123456, 0, 999, -1, 8388607, -42};
  localparam bit  vecF [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};

  logic clk = 0, rstN = 0, inValid = 0, freeze = 0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic outValid;
  logic [23:0] leftOut, rightOut;
  int checks = 0, errors = 0;
  bit done = 0;
  longint accM [2];

  always #2.5 clk = ~clk;

  dc_trim_top u_dut (.clk(clk), .rstN(rstN), .inValid(inValid), .freeze(freeze),
    .leftIn(leftIn), .rightIn(rightIn), .outValid(outValid),
    .leftOut(leftOut), .rightOut(rightOut));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampIt(longint v);
    if (v > PMAX) return PMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  // Drive one pair, check one cycle later against the model (R2 R3 R4 R5)
  task automatic sendPair(int l, int r, bit f, string req);
    longint expL, expR;
    expL = clampIt(longint'(l) - (accM[0] >>> KSH));
    expR = clampIt(longint'(r) - (accM[1] >>> KSH));
    if (!f) begin
      accM[0] = accM[0] + (((longint'(l)) * 8192 - accM[0]) >>> KSH);
      accM[1] = accM[1] + (((longint'(r)) * 8192 - accM[1]) >>> KSH);
    end
    @(negedge clk);
    leftIn = l[23:0]; rightIn = r[23:0]; freeze = f; inValid = 1;
    @(negedge clk);
    inValid = 0;
    check({req, " outValid R2"}, outValid, 1);
    check({req, " left"}, longint'($signed(leftOut)), expL);
    check({req, " right"}, longint'($signed(rightOut)), expR);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    accM[0] = 0; accM[1] = 0;
    @(negedge clk);
    check("R1 reset outValid", outValid, 0);
    check("R1 reset leftOut", leftOut, 0);
    check("R1 reset rightOut", rightOut, 0);
    rstN = 1;
  endtask

  initial begin
    logic [23:0] holdL, holdR;
    doReset();
    // R1: first sample after reset passes unchanged
    sendPair(-1234567, 7654321, 0, "R1 first");
    check("R1 pass left", longint'($signed(leftOut)), -1234567);
    // table walk: R3 R4 R5 R7
    for (int i = 0; i < NV; i++) sendPair(vecL[i], vecR[i], vecF[i], "R3/R4/R5/R7 table");
    // idle: R2 strobe low, R8 outputs held
    holdL = leftOut; holdR = rightOut;
    leftIn = 24'h123456; rightIn = 24'h654321;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 idle outValid", outValid, 0);
      check("R8 hold left", leftOut, holdL);
      check("R8 hold right", rightOut, holdR);
    end
    // settle with opposite DC on the two channels: R4 R7
    for (int i = 0; i < 6000; i++) sendPair(NMIN, PMAX, 0, "R4 settle");
    // freeze then opposite full scale: R5 R6
    sendPair(PMAX, NMIN, 1, "R5 frozen");
    check("R6 positive clamp", longint'($signed(leftOut)), PMAX);
    check("R6 negative clamp", longint'($signed(rightOut)), NMIN);
    for (int i = 0; i < 3; i++) sendPair(1000 * i, -1000 * i, 1, "R5 held estimate");
    // resume adaptation
    for (int i = 0; i < 5; i++) sendPair(0, 0, 0, "R4 resume");
    // reset mid-run: R1
    doReset();
    sendPair(555, -555, 0, "R1 after reset");
    check("R1 clear left", longint'($signed(leftOut)), 555);
    check("R1 clear right", longint'($signed(rightOut)), -555);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule